// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a synchronous DRAM burst. A start strobe captures an 8-bit start column together with the programmed burst settings: a length of 1, 2, 4 or 8 beats or a full row, and either linear or XOR ordering. Each cycle that the advance enable is high, the sequencer steps to the next beat. It raises a valid flag while a burst is running and a last flag on the final beat of a finite burst.

Full-row bursts step through all 256 columns, wrap from 255 back to 0, and keep running until the terminate input ends them. A write can be set up to touch only its start column while reads still burst at the programmed length. The settings are latched when the burst starts, so the controller may change its configuration inputs in the middle of a burst.

The controller follows three states. IDLE leaves on "launch" to FIXED for a finite burst or to PAGE for a full-row burst. FIXED returns to IDLE on "complete", which is advance on the final beat, or on "abort", which is terminate. PAGE returns to IDLE only on "abort". From FIXED or PAGE, "relaunch" (a new start) reloads the burst and enters FIXED or PAGE according to the new settings.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid and last are 0 and col is 0.
- R2: When start is high at a clock edge, the next cycle shows valid = 1 and col = start_col (beat 0).
- R3: In linear order with length BL, beat i has column (start_col with its low log2(BL) bits cleared) + ((start_col + i) mod BL). The upper bits never change.
- R4: In XOR order with length BL, the low log2(BL) bits of beat i are the low bits of start_col XOR i. The upper bits are those of start_col.
- R5: Length code cfg_len gives: 0 → 1 beat, 1 → 2, 2 → 4, 3 → 8, 7 → full row. Codes 4, 5 and 6 give 1 beat.
- R6: last is high exactly on beat BL-1 of a finite burst. Advance on that beat drops valid in the next cycle.
- R7: A full-row burst adds 1 to col modulo 256 on each advance, never raises last, and always uses linear order whatever cfg_interleave says.
- R8: When terminate is high and start is low, valid is 0 in the next cycle.
- R9: A start during a running burst abandons that burst and begins the new one. Start takes priority over terminate and advance in the same cycle.
- R10: When cfg_write_single = 1 and start_write = 1 at start, the burst has one beat whatever cfg_len is. Reads keep the programmed length.
- R11: While valid is high and advance, start and terminate are all low, col, last and valid hold.
- R12: Changes to cfg_len or cfg_interleave during a burst have no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 3 | Burst length code (see R5) |
| cfg_interleave | input | 1 | 1 = XOR order, 0 = linear order |
| cfg_write_single | input | 1 | 1 = write bursts are a single beat |
| start | input | 1 | Launch a burst at start_col |
| start_write | input | 1 | The burst being launched is a write |
| start_col | input | 8 | First column of the burst |
| advance | input | 1 | Step to the next beat |
| terminate | input | 1 | End the running burst |
| col | output | 8 | Column of the current beat |
| valid | output | 1 | A burst beat is being presented |
| last | output | 1 | Current beat is the final beat of a finite burst |

## Verification
A new start can arrive in the same cycle as a terminate or as the advance on the final beat. In either case the burst must reload rather than go idle. The bench provokes this by raising start together with advance in the middle of an 8-beat burst, and together with terminate in the middle of a 4-beat burst. The scoreboard then requires the next beat shown to be beat 0 of the new burst, with its own length and ordering.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Burst length codes
    localparam logic [2:0] LEN_1    = 3'd0;
    localparam logic [2:0] LEN_2    = 3'd1;
    localparam logic [2:0] LEN_4    = 3'd2;
    localparam logic [2:0] LEN_8    = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             force_single,
    output logic [COL_W-1:0] beat_mask,
    output logic             is_page
);
    always_comb begin
        beat_mask = '0;
        is_page   = 1'b0;
        if (!force_single) begin
            unique case (len_code)
                LEN_2:    beat_mask = COL_W'(1);
                LEN_4:    beat_mask = COL_W'(3);
                LEN_8:    beat_mask = COL_W'(7);
                LEN_PAGE: begin
                    beat_mask = '1;
                    is_page   = 1'b1;
                end
                default:  beat_mask = '0;
            endcase
        end
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] beat_mask,
    input  logic             xor_order,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] low_bits;

    always_comb begin
        if (xor_order) low_bits = base ^ beat;
        else           low_bits = base + beat;
        col = (base & ~beat_mask) | (low_bits & beat_mask);
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_interleave,
    input  logic             cfg_write_single,
    input  logic             start,
    input  logic             start_write,
    input  logic [COL_W-1:0] start_col,
    input  logic             advance,
    input  logic             terminate,
    output logic [COL_W-1:0] col,
    output logic             valid,
    output logic             last
);
    seq_state_e       state_q, state_d;
    logic [COL_W-1:0] base_q, beat_q, mask_q;
    logic             xor_q;
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             at_final;

    burst_len_decode #(.COL_W(COL_W)) len_dec_i (
        .len_code     (cfg_len),
        .force_single (cfg_write_single & start_write),
        .beat_mask    (dec_mask),
        .is_page      (dec_page)
    );

    burst_addr_gen #(.COL_W(COL_W)) addr_gen_i (
        .base      (base_q),
        .beat      (beat_q),
        .beat_mask (mask_q),
        .xor_order (xor_q),
        .col       (col)
    );

    assign at_final = (beat_q == mask_q);

    // Next-state selection: launch, relaunch, complete, abort
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = dec_page ? ST_PAGE : ST_FIXED;
            end
            ST_FIXED: begin
                if (start)                      state_d = dec_page ? ST_PAGE : ST_FIXED;
                else if (terminate)             state_d = ST_IDLE;
                else if (advance && at_final)   state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (start)          state_d = dec_page ? ST_PAGE : ST_FIXED;
                else if (terminate) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Burst context captured at launch, beat counter stepped on advance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
            mask_q <= '0;
            xor_q  <= 1'b0;
        end else if (start) begin
            base_q <= start_col;
            beat_q <= '0;
            mask_q <= dec_mask;
            xor_q  <= cfg_interleave & ~dec_page;
        end else if (advance && state_q != ST_IDLE) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        valid = (state_q != ST_IDLE);
        last  = (state_q == ST_FIXED) && at_final;
    end

    // R2: a launch presents its start column next cycle
    assert_launch_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (valid && col == $past(start_col)));

    // R6: advancing on the final beat ends the burst
    assert_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (last && advance && !start) |=> !valid);

    // R7: full-row bursts step by one modulo the row size
    assert_page_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE && advance && !start && !terminate)
            |=> (col == COL_W'($past(col) + 1'b1) && !last));

    // R8: terminate ends the burst
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (terminate && !start) |=> !valid);

    // R11: without a request the beat is held
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start && !advance && !terminate)
            |=> (valid && $stable(col) && $stable(last)));
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cfg_len;
    logic       cfg_interleave, cfg_write_single;
    logic       start, start_write, advance, terminate;
    logic [7:0] start_col, col;
    logic       valid, last;

    int checks = 0;
    int fails  = 0;
    logic [8:0] exp_q[$];
    string      req_q[$];
    logic [8:0] mon_exp;
    string      mon_req;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_interleave(cfg_interleave),
        .cfg_write_single(cfg_write_single), .start(start), .start_write(start_write),
        .start_col(start_col), .advance(advance), .terminate(terminate),
        .col(col), .valid(valid), .last(last)
    );

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push(int c, bit l, string req);
        exp_q.push_back({l, 8'(c)});
        req_q.push_back(req);
    endtask

    task automatic step(bit st, bit adv, bit term, int c, bit wr);
        @(negedge clk);
        start = st; advance = adv; terminate = term;
        start_col = 8'(c); start_write = wr;
    endtask

    function automatic int exp_col(int base, int beat, int bl, bit il);
        int blk = base - (base % bl);
        if (il) return blk + ((base % bl) ^ (beat % bl));
        return blk + ((base + beat) % bl);
    endfunction

    task automatic run_burst(int base, logic [2:0] code, int bl, bit il, string req);
        cfg_len = code; cfg_interleave = il;
        for (int i = 0; i < bl; i++) push(exp_col(base, i, bl, il), i == bl - 1, req);
        step(1, 0, 0, base, 0);
        for (int i = 0; i < bl; i++) step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 1'b0, {req, " end of burst (R6)"}, valid, 0);
    endtask

    // Scoreboard monitor: one expected item per valid cycle
    always @(negedge clk) begin
        if (rst_n && valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "scoreboard unexpected beat", {last, col}, 0);
            end else begin
                mon_exp = exp_q.pop_front();
                mon_req = req_q.pop_front();
                chk({last, col} == mon_exp, mon_req, {last, col}, mon_exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_len = 3'd0; cfg_interleave = 1'b0; cfg_write_single = 1'b0;
        start = 0; start_write = 0; advance = 0; terminate = 0; start_col = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(valid == 0 && last == 0 && col == 0, "R1 reset state", {valid, last, col}, 0);

        // R3 / R4 / R5 / R6: finite bursts in both orders
        run_burst(8'h35, 3'd3, 8, 0, "R3 linear BL8");
        run_burst(8'h35, 3'd3, 8, 1, "R4 xor BL8");
        run_burst(8'hFE, 3'd2, 4, 0, "R3 linear BL4 wrap");
        run_burst(8'h11, 3'd1, 2, 1, "R4 xor BL2");
        run_burst(8'h80, 3'd0, 1, 0, "R5 BL1");
        run_burst(8'h80, 3'd5, 1, 1, "R5 reserved code");

        // R7 / R8: full row, XOR setting ignored, wrap past 255, then terminate
        cfg_len = 3'd7; cfg_interleave = 1'b1;
        for (int i = 0; i < 7; i++) push((8'hFD + i) % 256, 0, "R7 full row");
        step(1, 0, 0, 8'hFD, 0);
        for (int i = 0; i < 6; i++) step(0, 1, 0, 0, 0);
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 0, "R8 terminate", valid, 0);

        // R11: hold without advance
        cfg_len = 3'd2; cfg_interleave = 1'b0;
        push(8'h40, 0, "R11 hold"); push(8'h40, 0, "R11 hold"); push(8'h40, 0, "R11 hold");
        push(8'h41, 0, "R11 hold"); push(8'h42, 0, "R11 hold"); push(8'h43, 1, "R11 hold");
        step(1, 0, 0, 8'h40, 0);
        step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0);
        repeat (4) step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 0, "R11 end", valid, 0);

        // R9: restart with advance, then restart with terminate
        cfg_len = 3'd3;
        push(8'h10, 0, "R9 first"); push(8'h11, 0, "R9 first"); push(8'h12, 0, "R9 first");
        push(8'h90, 0, "R9 restart"); push(8'h91, 1, "R9 restart");
        push(8'h20, 0, "R9 second"); push(8'h21, 0, "R9 second");
        push(8'h57, 1, "R9 start beats terminate"); push(8'h57, 1, "R9 start beats terminate");
        step(1, 0, 0, 8'h10, 0);
        step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
        cfg_len = 3'd1; cfg_interleave = 1'b1;
        step(1, 1, 0, 8'h90, 0);
        step(0, 1, 0, 0, 0); step(0, 1, 0, 0, 0);
        cfg_len = 3'd2; cfg_interleave = 1'b0;
        step(1, 0, 0, 8'h20, 0);
        step(0, 1, 0, 0, 0);
        cfg_len = 3'd0;
        step(1, 0, 1, 8'h57, 0);
        step(0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 0, "R9 end", valid, 0);

        // R10: single-beat write, read still bursts
        cfg_write_single = 1'b1; cfg_len = 3'd3;
        push(8'h66, 1, "R10 single write");
        step(1, 0, 0, 8'h66, 1);
        step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 0, "R10 write end", valid, 0);
        run_burst(8'h66, 3'd2, 4, 0, "R10 read bursts");
        cfg_write_single = 1'b0;

        // R12: configuration changed mid-burst
        cfg_len = 3'd2; cfg_interleave = 1'b0;
        push(8'h08, 0, "R12 cfg latched"); push(8'h09, 0, "R12 cfg latched");
        push(8'h0A, 0, "R12 cfg latched"); push(8'h0B, 1, "R12 cfg latched");
        step(1, 0, 0, 8'h08, 0);
        step(0, 1, 0, 0, 0);
        cfg_len = 3'd7; cfg_interleave = 1'b1;
        repeat (3) step(0, 1, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk(valid == 0, "R12 end", valid, 0);

        step(0, 0, 0, 0, 0);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule